// File: doc/BRIEF.md
# USB Host Receive Endpoint Control/Status Register

This block is the 16-bit control and status register of one receive endpoint on the host side of a USB controller. Software accesses it over a simple register bus that has a write strobe, a read strobe and write and read data. The endpoint engine reports what happens on the wire through single-cycle event inputs: a packet arrived, a STALL was seen, retries ran out, a data error or NAK timeout occurred, or the data toggle advanced.

The register holds the receive data toggle, a few configuration bits, the IN-request bit and four sticky status flags. Some bits are commands that clear themselves. The block returns one-cycle pulses to the engine for a FIFO flush and for a toggle clear, gives it the IN-request level and the current toggle, and raises a one-cycle interrupt pulse when one of the interrupt-generating flags becomes set.

The reset input is asynchronous and active low. Its release must already be synchronised to `clk`.

Top module: `usb_hrx_ctl_reg`

## Requirements
- R1: After reset every register field is 0. A read returns 0x0000, and `irq`, `req_active`, `toggle_out`, `flush_pulse` and `tgl_clr_pulse` are all 0.
- R2: The bit positions are: 13 DMA request enable, 12 NYET disable, 11 DMA mode (all plain read/write), 10 toggle write enable, 9 data toggle, 7 toggle clear, 6 stall seen, 5 IN request, 4 flush, 3 data error / NAK timeout, 2 retry error, 1 FIFO full, 0 packet ready. Bits 15:14, 10, 8, 7 and 4 always read as 0.
- R3: A write changes the data toggle (bit 9) only if bit 10 is 1 in the same write. Otherwise the value written to bit 9 is ignored.
- R4: The toggle write enable clears itself once the toggle has been written, so bit 10 reads back as 0 on the next cycle.
- R5: Writing 1 to bit 7 forces the toggle to 0 on the next cycle, with priority over a toggle write and over an engine toggle flip. It also raises `tgl_clr_pulse` for exactly one cycle.
- R6: When software is not acting on the toggle, an `ev_toggle_flip` pulse inverts the toggle.
- R7: Writing bit 5 sets or clears the IN request, and `req_active` follows it. An `ev_pkt` pulse clears the request on the same edge that sets packet ready, and this wins over a software write of 1.
- R8: Writing 1 to bit 4 while packet ready is 1 clears packet ready and raises `flush_pulse` for one cycle. While packet ready is 0, the flush write does nothing.
- R9: The packet ready (bit 0), stall (bit 6) and retry error (bit 2) flags are set by `ev_pkt`, `ev_stall` and `ev_err`. A write of 0 to a flag's bit clears it and a write of 1 leaves it unchanged. If a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R10: `irq` is a one-cycle pulse in the cycle after one or more of bits 0, 6 and 2 go from 0 to 1. An event on a flag that is already set raises no pulse.
- R11: `ev_data_err` sets bit 3. A write of 0 clears it, and it never raises `irq`.
- R12: Bit 1 returns the level of `fifo_full` sampled at the read.
- R13: `bus_rdata` is loaded on the clock edge at which `bus_rd` is 1 and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| ev_pkt | input | 1 | Engine: packet received |
| ev_stall | input | 1 | Engine: STALL handshake received |
| ev_err | input | 1 | Engine: retries exhausted |
| ev_data_err | input | 1 | Engine: data error or NAK timeout |
| ev_toggle_flip | input | 1 | Engine: data toggle advances |
| fifo_full | input | 1 | Engine: receive FIFO cannot accept another packet |
| irq | output | 1 | One-cycle interrupt pulse |
| req_active | output | 1 | IN request pending |
| flush_pulse | output | 1 | One-cycle FIFO flush command |
| tgl_clr_pulse | output | 1 | One-cycle toggle clear command |
| toggle_out | output | 1 | Current data toggle |
| dma_req_en | output | 1 | DMA request enable |
| nyet_off | output | 1 | NYET handshakes disabled |
| dma_mode | output | 1 | DMA mode configuration bit |

## Verification
The hardest case to reach is a collision: a hardware event and a software write that act on the same flag in the same clock cycle. The bench drives a clearing write and `ev_stall` on one edge, then checks that the flag stays set and that the interrupt still fires. Some outcomes depend on state built up beforehand, so the tests run in a fixed order. A flush issued while packet ready is set must be followed by a flush issued while it is clear. An `ev_pkt` that arrives with packet ready already set must raise no interrupt pulse.

// File: rtl/hrx_csr_pkg.sv
package hrx_csr_pkg;
  localparam int CSR_W = 16;

  // bit positions inside the register word
  localparam int B_RDY    = 0;
  localparam int B_FULL   = 1;
  localparam int B_ERR    = 2;
  localparam int B_DERR   = 3;
  localparam int B_FLUSH  = 4;
  localparam int B_REQ    = 5;
  localparam int B_STALL  = 6;
  localparam int B_CLRT   = 7;
  localparam int B_TOG    = 9;
  localparam int B_TWEN   = 10;
  localparam int B_DMAM   = 11;
  localparam int B_NONYET = 12;
  localparam int B_DMAEN  = 13;

  // sticky flag bank indices
  localparam int NFLAG    = 4;
  localparam int FL_RDY   = 0;
  localparam int FL_ERR   = 1;
  localparam int FL_DERR  = 2;
  localparam int FL_STALL = 3;

  // flags that raise an interrupt when they become set
  localparam logic [NFLAG-1:0] FLAG_IRQ = 4'b1011;

  function automatic int flag_pos(input int idx);
    case (idx)
      FL_RDY:  flag_pos = B_RDY;
      FL_ERR:  flag_pos = B_ERR;
      FL_DERR: flag_pos = B_DERR;
      default: flag_pos = B_STALL;
    endcase
  endfunction

  typedef struct packed {
    logic dma_en;
    logic nonyet;
    logic dma_mode;
  } cfg_t;
endpackage

// File: rtl/hrx_cmd_decode.sv
module hrx_cmd_decode
  import hrx_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CSR_W-1:0] wdata,
  input  logic             rdy_q,
  input  logic             ev_pkt,
  output cfg_t             cfg_q,
  output logic             req_q,
  output logic             flush_pulse_q,
  output logic             tclr_pulse_q,
  output logic             tog_wr_en,
  output logic             tog_wr_val,
  output logic             tclr_now,
  output logic [NFLAG-1:0] flag_clr
);
  cfg_t cfg_d;
  logic req_d;
  logic flush_now;

  // command decode
  always_comb begin
    tog_wr_en  = wr & wdata[B_TWEN];
    tog_wr_val = wdata[B_TOG];
    tclr_now   = wr & wdata[B_CLRT];
    flush_now  = wr & wdata[B_FLUSH] & rdy_q;
  end

  // software clear of sticky flags: writing 0 clears, flush also clears ready
  for (genvar i = 0; i < NFLAG; i++) begin : g_clr
    if (i == FL_RDY) begin : g_rdy
      assign flag_clr[i] = wr & (~wdata[flag_pos(i)] | flush_now);
    end else begin : g_other
      assign flag_clr[i] = wr & ~wdata[flag_pos(i)];
    end
  end

  // next state
  always_comb begin
    cfg_d = cfg_q;
    if (wr) begin
      cfg_d.dma_en   = wdata[B_DMAEN];
      cfg_d.nonyet   = wdata[B_NONYET];
      cfg_d.dma_mode = wdata[B_DMAM];
    end
    req_d = req_q;
    if (wr) req_d = wdata[B_REQ];
    if (ev_pkt) req_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q         <= '0;
      req_q         <= 1'b0;
      flush_pulse_q <= 1'b0;
      tclr_pulse_q  <= 1'b0;
    end else begin
      cfg_q         <= cfg_d;
      req_q         <= req_d;
      flush_pulse_q <= flush_now;
      tclr_pulse_q  <= tclr_now;
    end
  end
endmodule

// File: rtl/hrx_toggle.sv
module hrx_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr_en,
  input  logic wr_val,
  input  logic flip,
  output logic tog_q
);
  logic tog_d;

  // priority: clear, then software write, then engine advance
  always_comb begin
    if (clr)        tog_d = 1'b0;
    else if (wr_en) tog_d = wr_val;
    else if (flip)  tog_d = ~tog_q;
    else            tog_d = tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end
endmodule

// File: rtl/hrx_flag_bank.sv
module hrx_flag_bank #(
  parameter int               N        = 4,
  parameter logic [N-1:0]     IRQ_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag_q,
  output logic         irq_q
);
  logic [N-1:0] flag_d;
  logic         irq_d;

  // hardware set wins over software clear
  for (genvar i = 0; i < N; i++) begin : g_flag
    assign flag_d[i] = set[i] ? 1'b1 : (clr[i] ? 1'b0 : flag_q[i]);
  end

  always_comb irq_d = |(IRQ_MASK & flag_d & ~flag_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/hrx_read_mux.sv
module hrx_read_mux
  import hrx_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  cfg_t             cfg,
  input  logic             tog,
  input  logic             req,
  input  logic [NFLAG-1:0] flags,
  input  logic             full,
  output logic [CSR_W-1:0] rdata_q
);
  logic [CSR_W-1:0] word;
  logic [CSR_W-1:0] rdata_d;

  always_comb begin
    word           = '0;
    word[B_DMAEN]  = cfg.dma_en;
    word[B_NONYET] = cfg.nonyet;
    word[B_DMAM]   = cfg.dma_mode;
    word[B_TOG]    = tog;
    word[B_REQ]    = req;
    word[B_FULL]   = full;
    for (int i = 0; i < NFLAG; i++) word[flag_pos(i)] = flags[i];
  end

  // clock enable: load only on a read strobe
  always_comb rdata_d = rd ? word : rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end
endmodule

// File: rtl/usb_hrx_ctl_reg.sv
module usb_hrx_ctl_reg
  import hrx_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [CSR_W-1:0] bus_wdata,
  output logic [CSR_W-1:0] bus_rdata,
  input  logic             ev_pkt,
  input  logic             ev_stall,
  input  logic             ev_err,
  input  logic             ev_data_err,
  input  logic             ev_toggle_flip,
  input  logic             fifo_full,
  output logic             irq,
  output logic             req_active,
  output logic             flush_pulse,
  output logic             tgl_clr_pulse,
  output logic             toggle_out,
  output logic             dma_req_en,
  output logic             nyet_off,
  output logic             dma_mode
);
  cfg_t             cfg_q;
  logic             req_q;
  logic             tog_q;
  logic             tog_wr_en;
  logic             tog_wr_val;
  logic             tclr_now;
  logic [NFLAG-1:0] flag_clr;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_q;

  always_comb begin
    flag_set           = '0;
    flag_set[FL_RDY]   = ev_pkt;
    flag_set[FL_ERR]   = ev_err;
    flag_set[FL_DERR]  = ev_data_err;
    flag_set[FL_STALL] = ev_stall;
  end

  hrx_cmd_decode u_dec (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr            (bus_wr),
    .wdata         (bus_wdata),
    .rdy_q         (flag_q[FL_RDY]),
    .ev_pkt        (ev_pkt),
    .cfg_q         (cfg_q),
    .req_q         (req_q),
    .flush_pulse_q (flush_pulse),
    .tclr_pulse_q  (tgl_clr_pulse),
    .tog_wr_en     (tog_wr_en),
    .tog_wr_val    (tog_wr_val),
    .tclr_now      (tclr_now),
    .flag_clr      (flag_clr)
  );

  hrx_toggle u_tog (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tclr_now),
    .wr_en  (tog_wr_en),
    .wr_val (tog_wr_val),
    .flip   (ev_toggle_flip),
    .tog_q  (tog_q)
  );

  hrx_flag_bank #(
    .N        (NFLAG),
    .IRQ_MASK (FLAG_IRQ)
  ) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (flag_set),
    .clr    (flag_clr),
    .flag_q (flag_q),
    .irq_q  (irq)
  );

  hrx_read_mux u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (bus_rd),
    .cfg     (cfg_q),
    .tog     (tog_q),
    .req     (req_q),
    .flags   (flag_q),
    .full    (fifo_full),
    .rdata_q (bus_rdata)
  );

  assign req_active = req_q;
  assign toggle_out = tog_q;
  assign dma_req_en = cfg_q.dma_en;
  assign nyet_off   = cfg_q.nonyet;
  assign dma_mode   = cfg_q.dma_mode;
endmodule

// File: rtl/hrx_csr_chk.sv
module hrx_csr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic        ev_pkt,
  input logic        ev_stall,
  input logic        ev_err,
  input logic        ev_toggle_flip,
  input logic        irq,
  input logic        req_active,
  input logic        flush_pulse,
  input logic        tgl_clr_pulse,
  input logic        toggle_out
);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[15:14] == 2'b00) && !bus_rdata[10] && !bus_rdata[8]
    && !bus_rdata[7] && !bus_rdata[4]);

  // R7
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pkt |=> !req_active);

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgl_clr_pulse |-> !toggle_out);

  // R8
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> $past(bus_wr && bus_wdata[4]));

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ev_pkt || ev_stall || ev_err));

  // R3
  tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_wdata[10] && !bus_wdata[7] && !ev_toggle_flip) |=> $stable(toggle_out));
endmodule

bind usb_hrx_ctl_reg hrx_csr_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_wr         (bus_wr),
  .bus_wdata      (bus_wdata),
  .bus_rdata      (bus_rdata),
  .ev_pkt         (ev_pkt),
  .ev_stall       (ev_stall),
  .ev_err         (ev_err),
  .ev_toggle_flip (ev_toggle_flip),
  .irq            (irq),
  .req_active     (req_active),
  .flush_pulse    (flush_pulse),
  .tgl_clr_pulse  (tgl_clr_pulse),
  .toggle_out     (toggle_out)
);

// File: tb/sim_usb_hrx_ctl_reg.sv
`timescale 1ns/1ps
module sim_usb_hrx_ctl_reg;
  logic        clk;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic        ev_pkt, ev_stall, ev_err, ev_data_err, ev_toggle_flip, fifo_full;
  logic        irq, req_active, flush_pulse, tgl_clr_pulse, toggle_out;
  logic        dma_req_en, nyet_off, dma_mode;

  int total = 0;
  int bad   = 0;

  usb_hrx_ctl_reg u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_pkt(ev_pkt), .ev_stall(ev_stall), .ev_err(ev_err),
    .ev_data_err(ev_data_err), .ev_toggle_flip(ev_toggle_flip),
    .fifo_full(fifo_full), .irq(irq), .req_active(req_active),
    .flush_pulse(flush_pulse), .tgl_clr_pulse(tgl_clr_pulse),
    .toggle_out(toggle_out), .dma_req_en(dma_req_en),
    .nyet_off(nyet_off), .dma_mode(dma_mode)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: run hung, actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse(ref logic ev);
    @(negedge clk); ev = 1'b1;
    @(negedge clk); ev = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 req_active", {15'd0, req_active}, 16'd0);
    chk("R1 toggle_out", {15'd0, toggle_out}, 16'd0);
    chk("R1 pulses", {14'd0, flush_pulse, tgl_clr_pulse}, 16'd0);
    rd(v); chk("R1 read", v, 16'h0000);
  endtask

  task automatic t_cfg;
    logic [15:0] v;
    wr(16'h3800);
    chk("R2 cfg outputs", {13'd0, dma_req_en, nyet_off, dma_mode}, 16'h0007);
    rd(v); chk("R2 cfg read", v, 16'h3800);
    wr(16'hFFFF);
    chk("R5 clear beats write", {15'd0, toggle_out}, 16'd0);
    chk("R5 clear pulse", {15'd0, tgl_clr_pulse}, 16'd1);
    chk("R8 flush ignored", {15'd0, flush_pulse}, 16'd0);
    rd(v); chk("R2 all-ones read", v, 16'h3820);
    wr(16'h0000);
  endtask

  task automatic t_toggle;
    logic [15:0] v;
    wr(16'h0200); chk("R3 gated write", {15'd0, toggle_out}, 16'd0);
    wr(16'h0600); chk("R3 enabled write", {15'd0, toggle_out}, 16'd1);
    rd(v); chk("R4 enable self-clear", v, 16'h0200);
    pulse(ev_toggle_flip); chk("R6 flip 1->0", {15'd0, toggle_out}, 16'd0);
    pulse(ev_toggle_flip); chk("R6 flip 0->1", {15'd0, toggle_out}, 16'd1);
    wr(16'h0080);
    chk("R5 clear", {15'd0, toggle_out}, 16'd0);
    chk("R5 pulse high", {15'd0, tgl_clr_pulse}, 16'd1);
    @(negedge clk); chk("R5 pulse one cycle", {15'd0, tgl_clr_pulse}, 16'd0);
  endtask

  task automatic t_req;
    logic [15:0] v;
    wr(16'h0020); chk("R7 req set", {15'd0, req_active}, 16'd1);
    rd(v); chk("R7 req read", v, 16'h0020);
    pulse(ev_pkt);
    chk("R7 req cleared by packet", {15'd0, req_active}, 16'd0);
    chk("R10 irq on ready", {15'd0, irq}, 16'd1);
    @(negedge clk); chk("R10 irq one cycle", {15'd0, irq}, 16'd0);
    rd(v); chk("R9 ready read", v, 16'h0001);
  endtask

  task automatic t_flush;
    logic [15:0] v;
    wr(16'h0011); chk("R8 flush pulse", {15'd0, flush_pulse}, 16'd1);
    rd(v); chk("R8 ready cleared", v, 16'h0000);
    wr(16'h0010); chk("R8 flush no effect", {15'd0, flush_pulse}, 16'd0);
    pulse(ev_pkt);
    wr(16'h0001); rd(v); chk("R9 write 1 keeps", v, 16'h0001);
    wr(16'h0000); rd(v); chk("R9 write 0 clears", v, 16'h0000);
  endtask

  task automatic t_race;
    logic [15:0] v;
    @(negedge clk); bus_wr = 1'b1; bus_wdata = 16'h0000; ev_stall = 1'b1;
    @(negedge clk); bus_wr = 1'b0; ev_stall = 1'b0;
    chk("R10 irq on stall", {15'd0, irq}, 16'd1);
    rd(v); chk("R9 set beats clear", v, 16'h0040);
    pulse(ev_pkt); chk("R10 irq ready rise", {15'd0, irq}, 16'd1);
    pulse(ev_pkt); chk("R10 no irq when set", {15'd0, irq}, 16'd0);
    rd(v); chk("R9 both flags", v, 16'h0041);
    wr(16'h0000);
  endtask

  task automatic t_errs;
    logic [15:0] v;
    pulse(ev_data_err); chk("R11 no irq", {15'd0, irq}, 16'd0);
    rd(v); chk("R11 data err read", v, 16'h0008);
    wr(16'h0000); rd(v); chk("R11 cleared", v, 16'h0000);
    pulse(ev_err); chk("R10 irq on error", {15'd0, irq}, 16'd1);
    rd(v); chk("R9 error read", v, 16'h0004);
    wr(16'h0000);
  endtask

  task automatic t_full;
    logic [15:0] v;
    @(negedge clk); fifo_full = 1'b1;
    rd(v); chk("R12 full read", v, 16'h0002);
    fifo_full = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R13 rdata holds", bus_rdata, 16'h0002);
    rd(v); chk("R12 full cleared", v, 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    ev_pkt = 1'b0; ev_stall = 1'b0; ev_err = 1'b0; ev_data_err = 1'b0;
    ev_toggle_flip = 1'b0; fifo_full = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg();
    t_toggle();
    t_req();
    t_flush();
    t_race();
    t_errs();
    t_full();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule